// File: doc/BRIEF.md
# LRU-Ordered Associative Translation Registers

This block is a small, fully associative set of translation registers. Each register maps one virtual page number to one physical page number. A lookup is answered in the same cycle it is presented. The registers are physically kept in recency order: position 0 holds the most recently used mapping. On every hit, the matching entry moves to position 0, and the entries that were in front of it each slide back one place. In monitor mode every lookup hits and returns the virtual page number unchanged as the physical page number. The contents are ignored in that mode and are not reordered.

A lookup that finds no valid match raises a miss, and the requester holds its access. An external handler can then save the whole register set through a dump port and refill it through a load port. Both ports work as a block transfer of one entry per cycle in index order. While either transfer runs, the block reports busy, answers no lookups and ignores new transfer starts.

Top module: `lru_xlate_regs`

## Requirements
- R1: After reset every entry is invalid with zero page numbers, busy_o is low, a normal-mode lookup misses, and a dump shows all entries invalid and zero.
- R2: With lkp_req_i high, busy_o low and lkp_mon_i low, a lookup that matches a valid entry raises lkp_hit_o and drives that entry's physical page on lkp_ppn_o in the same cycle. lkp_ppn_o is zero whenever lkp_hit_o is low.
- R3: A normal-mode hit at position k writes the hit entry to position 0 at the next edge. Entries 0..k-1 move to 1..k, and entries above k are unchanged.
- R4: A normal-mode lookup with no valid matching entry raises lkp_miss_o with lkp_hit_o low and leaves the order unchanged. lkp_hit_o and lkp_miss_o are never high together.
- R5: In monitor mode (lkp_mon_i high) an accepted lookup raises lkp_hit_o, drives lkp_ppn_o equal to lkp_vpn_i, and does not reorder the entries.
- R6: A dump_start_i pulse while idle makes busy_o and dump_valid_o high for the next N cycles. On those cycles dump_idx_o counts 0..N-1 and dump_vld_o, dump_vpn_o and dump_ppn_o show that entry.
- R7: A load_start_i pulse while idle makes busy_o high for the next N cycles. On the j-th of those cycles (j from 0), ld_vld_i, ld_vpn_i and ld_ppn_i are written to entry j at the clock edge.
- R8: While busy_o is high, lkp_hit_o and lkp_miss_o stay low, no reordering happens, and dump_start_i and load_start_i are ignored. When both starts arrive while idle, the dump is taken.
- R9: An entry whose valid bit is clear never matches.
- R10: When several valid entries match, the lowest-numbered one supplies the result and is the one moved to position 0.
- R11: With lkp_req_i low, lkp_hit_o and lkp_miss_o are low and the entries do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lkp_req_i | input | 1 | Lookup request |
| lkp_mon_i | input | 1 | Monitor mode (identity mapping) |
| lkp_vpn_i | input | PN_W | Virtual page number to translate |
| lkp_hit_o | output | 1 | Lookup hit |
| lkp_miss_o | output | 1 | Lookup miss |
| lkp_ppn_o | output | PN_W | Translated physical page number |
| dump_start_i | input | 1 | Start a block dump of all entries |
| load_start_i | input | 1 | Start a block load of all entries |
| ld_vld_i | input | 1 | Valid bit for the entry being loaded |
| ld_vpn_i | input | PN_W | Virtual page for the entry being loaded |
| ld_ppn_i | input | PN_W | Physical page for the entry being loaded |
| busy_o | output | 1 | A dump or load transfer is in progress |
| dump_valid_o | output | 1 | Dump data valid this cycle |
| dump_idx_o | output | $clog2(N) | Position of the entry being dumped |
| dump_vld_o | output | 1 | Valid bit of the dumped entry |
| dump_vpn_o | output | PN_W | Virtual page of the dumped entry |
| dump_ppn_o | output | PN_W | Physical page of the dumped entry |

## Verification
A wrong recency order stays hidden on the lookup port for as long as every entry's contents survive. It shows only through a full dump, or through the priority between duplicate entries once they have moved past each other. For that reason the order is dumped after every burst of lookups. A corrupted entry or valid bit shows at once: the next lookup of that page returns the wrong hit, miss or physical page in the same cycle. A sequencer fault shows within one transfer, as a busy window that is not exactly N cycles long or as a dump index that skips.

// File: rtl/lru_xlate_pkg.sv
package lru_xlate_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_DUMP = 2'd1,
    SEQ_LOAD = 2'd2
  } seq_state_e;
endpackage

// File: rtl/lru_xlate_match.sv
module lru_xlate_match #(
  parameter int N     = 16,
  parameter int PN_W  = 20,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]           vld_i,
  input  logic [N-1:0][PN_W-1:0] vpn_i,
  input  logic [PN_W-1:0]        key_i,
  output logic                   any_o,
  output logic [IDX_W-1:0]       idx_o
);
  logic [N-1:0] hit_vec;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = vld_i[g] && (vpn_i[g] == key_i);
  end

  assign any_o = |hit_vec;

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (hit_vec[k]) idx_o = IDX_W'(k);
    end
  end
endmodule

// File: rtl/lru_xlate_seq.sv
module lru_xlate_seq
  import lru_xlate_pkg::*;
#(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dump_start_i,
  input  logic             load_start_i,
  output logic             busy_o,
  output logic             dump_act_o,
  output logic             load_act_o,
  output logic [IDX_W-1:0] cnt_o
);
  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last = (cnt_q == IDX_W'(N - 1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SEQ_IDLE: begin
        cnt_d = '0;
        if (dump_start_i)      state_d = SEQ_DUMP;
        else if (load_start_i) state_d = SEQ_LOAD;
      end
      SEQ_DUMP, SEQ_LOAD: begin
        if (last) begin
          state_d = SEQ_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign dump_act_o = (state_q == SEQ_DUMP);
  assign load_act_o = (state_q == SEQ_LOAD);
  assign busy_o     = dump_act_o | load_act_o;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/lru_xlate_array.sv
module lru_xlate_array #(
  parameter int N     = 16,
  parameter int PN_W  = 20,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   promote_i,
  input  logic [IDX_W-1:0]       promote_idx_i,
  input  logic                   wr_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic                   wr_vld_i,
  input  logic [PN_W-1:0]        wr_vpn_i,
  input  logic [PN_W-1:0]        wr_ppn_i,
  output logic [N-1:0]           vld_o,
  output logic [N-1:0][PN_W-1:0] vpn_o,
  output logic [N-1:0][PN_W-1:0] ppn_o
);
  logic [N-1:0]           vld_q;
  logic [N-1:0][PN_W-1:0] vpn_q;
  logic [N-1:0][PN_W-1:0] ppn_q;

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic            shift_in;
    logic            ld_here;
    logic            nx_vld;
    logic [PN_W-1:0] nx_vpn;
    logic [PN_W-1:0] nx_ppn;

    assign ld_here = wr_i && (wr_idx_i == IDX_W'(i));

    if (i == 0) begin : g_head
      assign shift_in = promote_i;
      assign nx_vld   = vld_q[promote_idx_i];
      assign nx_vpn   = vpn_q[promote_idx_i];
      assign nx_ppn   = ppn_q[promote_idx_i];
    end else begin : g_tail
      // entries in front of the hit slide back one place
      assign shift_in = promote_i && (IDX_W'(i) <= promote_idx_i);
      assign nx_vld   = vld_q[i-1];
      assign nx_vpn   = vpn_q[i-1];
      assign nx_ppn   = ppn_q[i-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[i] <= 1'b0;
        vpn_q[i] <= '0;
        ppn_q[i] <= '0;
      end else if (ld_here) begin
        vld_q[i] <= wr_vld_i;
        vpn_q[i] <= wr_vpn_i;
        ppn_q[i] <= wr_ppn_i;
      end else if (shift_in) begin
        vld_q[i] <= nx_vld;
        vpn_q[i] <= nx_vpn;
        ppn_q[i] <= nx_ppn;
      end
    end
  end

  assign vld_o = vld_q;
  assign vpn_o = vpn_q;
  assign ppn_o = ppn_q;
endmodule

// File: rtl/lru_xlate_regs.sv
module lru_xlate_regs #(
  parameter int N     = 16,
  parameter int PN_W  = 20,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lkp_req_i,
  input  logic             lkp_mon_i,
  input  logic [PN_W-1:0]  lkp_vpn_i,
  output logic             lkp_hit_o,
  output logic             lkp_miss_o,
  output logic [PN_W-1:0]  lkp_ppn_o,
  input  logic             dump_start_i,
  input  logic             load_start_i,
  input  logic             ld_vld_i,
  input  logic [PN_W-1:0]  ld_vpn_i,
  input  logic [PN_W-1:0]  ld_ppn_i,
  output logic             busy_o,
  output logic             dump_valid_o,
  output logic [IDX_W-1:0] dump_idx_o,
  output logic             dump_vld_o,
  output logic [PN_W-1:0]  dump_vpn_o,
  output logic [PN_W-1:0]  dump_ppn_o
);
  logic                   busy, dump_act, load_act;
  logic [IDX_W-1:0]       cnt;
  logic [N-1:0]           vld_tab;
  logic [N-1:0][PN_W-1:0] vpn_tab;
  logic [N-1:0][PN_W-1:0] ppn_tab;
  logic                   any_match;
  logic [IDX_W-1:0]       match_idx;
  logic                   lkp_go, promote;
  logic [PN_W-1:0]        front_vpn;

  lru_xlate_seq #(.N(N)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dump_start_i (dump_start_i),
    .load_start_i (load_start_i),
    .busy_o       (busy),
    .dump_act_o   (dump_act),
    .load_act_o   (load_act),
    .cnt_o        (cnt)
  );

  lru_xlate_match #(.N(N), .PN_W(PN_W)) u_match (
    .vld_i (vld_tab),
    .vpn_i (vpn_tab),
    .key_i (lkp_vpn_i),
    .any_o (any_match),
    .idx_o (match_idx)
  );

  assign lkp_go  = lkp_req_i && !busy;
  assign promote = lkp_go && !lkp_mon_i && any_match;

  lru_xlate_array #(.N(N), .PN_W(PN_W)) u_array (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .promote_i     (promote),
    .promote_idx_i (match_idx),
    .wr_i          (load_act),
    .wr_idx_i      (cnt),
    .wr_vld_i      (ld_vld_i),
    .wr_vpn_i      (ld_vpn_i),
    .wr_ppn_i      (ld_ppn_i),
    .vld_o         (vld_tab),
    .vpn_o         (vpn_tab),
    .ppn_o         (ppn_tab)
  );

  always_comb begin
    lkp_hit_o  = 1'b0;
    lkp_miss_o = 1'b0;
    lkp_ppn_o  = '0;
    if (lkp_go) begin
      if (lkp_mon_i) begin
        lkp_hit_o = 1'b1;
        lkp_ppn_o = lkp_vpn_i;
      end else if (any_match) begin
        lkp_hit_o = 1'b1;
        lkp_ppn_o = ppn_tab[match_idx];
      end else begin
        lkp_miss_o = 1'b1;
      end
    end
  end

  assign busy_o       = busy;
  assign dump_valid_o = dump_act;
  assign dump_idx_o   = dump_act ? cnt : '0;
  assign dump_vld_o   = dump_act && vld_tab[cnt];
  assign dump_vpn_o   = dump_act ? vpn_tab[cnt] : '0;
  assign dump_ppn_o   = dump_act ? ppn_tab[cnt] : '0;
  assign front_vpn    = vpn_tab[0];
endmodule

// File: rtl/lru_xlate_chk.sv
module lru_xlate_chk #(
  parameter int N     = 16,
  parameter int PN_W  = 20,
  localparam int IDX_W = $clog2(N)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lkp_req_i,
  input logic             lkp_mon_i,
  input logic [PN_W-1:0]  lkp_vpn_i,
  input logic             lkp_hit_o,
  input logic             lkp_miss_o,
  input logic [PN_W-1:0]  lkp_ppn_o,
  input logic             busy_o,
  input logic             dump_valid_o,
  input logic [IDX_W-1:0] dump_idx_o,
  input logic [PN_W-1:0]  front_vpn
);
  p_hit_miss_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lkp_hit_o && lkp_miss_o));

  p_req_resolves_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_req_i && !busy_o) |-> (lkp_hit_o || lkp_miss_o));

  p_ppn_zero_no_hit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_hit_o |-> (lkp_ppn_o == '0));

  p_busy_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!lkp_hit_o && !lkp_miss_o));

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_req_i |-> (!lkp_hit_o && !lkp_miss_o));

  p_mon_identity_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_req_i && lkp_mon_i && !busy_o) |-> (lkp_hit_o && lkp_ppn_o == lkp_vpn_i));

  p_front_after_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_hit_o && !lkp_mon_i) |=> (front_vpn == $past(lkp_vpn_i)));

  p_dump_first_idx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dump_valid_o) |-> (dump_idx_o == '0));

  p_dump_idx_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dump_valid_o && $past(dump_valid_o)) |-> (dump_idx_o == $past(dump_idx_o) + 1'b1));

  p_dump_in_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dump_valid_o |-> busy_o);
endmodule

bind lru_xlate_regs lru_xlate_chk #(.N(N), .PN_W(PN_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lkp_req_i    (lkp_req_i),
  .lkp_mon_i    (lkp_mon_i),
  .lkp_vpn_i    (lkp_vpn_i),
  .lkp_hit_o    (lkp_hit_o),
  .lkp_miss_o   (lkp_miss_o),
  .lkp_ppn_o    (lkp_ppn_o),
  .busy_o       (busy_o),
  .dump_valid_o (dump_valid_o),
  .dump_idx_o   (dump_idx_o),
  .front_vpn    (front_vpn)
);

// File: tb/lru_xlate_regs_bench.sv
module lru_xlate_regs_bench;
  localparam int N        = 16;
  localparam int PN_W     = 20;
  localparam int IDX_W    = $clog2(N);
  localparam int CLK_PER  = 10;
  localparam int WATCHDOG = 20000;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             lkp_req_i = 1'b0, lkp_mon_i = 1'b0;
  logic [PN_W-1:0]  lkp_vpn_i = '0;
  logic             lkp_hit_o, lkp_miss_o;
  logic [PN_W-1:0]  lkp_ppn_o;
  logic             dump_start_i = 1'b0, load_start_i = 1'b0;
  logic             ld_vld_i = 1'b0;
  logic [PN_W-1:0]  ld_vpn_i = '0, ld_ppn_i = '0;
  logic             busy_o, dump_valid_o, dump_vld_o;
  logic [IDX_W-1:0] dump_idx_o;
  logic [PN_W-1:0]  dump_vpn_o, dump_ppn_o;

  always #(CLK_PER/2) clk = ~clk;

  lru_xlate_regs #(.N(N), .PN_W(PN_W)) u_lru_xlate_regs (
    .clk_i(clk), .rst_ni(rst_ni),
    .lkp_req_i(lkp_req_i), .lkp_mon_i(lkp_mon_i), .lkp_vpn_i(lkp_vpn_i),
    .lkp_hit_o(lkp_hit_o), .lkp_miss_o(lkp_miss_o), .lkp_ppn_o(lkp_ppn_o),
    .dump_start_i(dump_start_i), .load_start_i(load_start_i),
    .ld_vld_i(ld_vld_i), .ld_vpn_i(ld_vpn_i), .ld_ppn_i(ld_ppn_i),
    .busy_o(busy_o), .dump_valid_o(dump_valid_o), .dump_idx_o(dump_idx_o),
    .dump_vld_o(dump_vld_o), .dump_vpn_o(dump_vpn_o), .dump_ppn_o(dump_ppn_o)
  );

  // behavioural reference
  bit          m_vld[N];
  int unsigned m_vpn[N];
  int unsigned m_ppn[N];
  int          m_mode;  // 0 idle, 1 dump, 2 load
  int          m_cnt;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int find(int unsigned v);
    for (int k = 0; k < N; k++) if (m_vld[k] && m_vpn[k] == v) return k;
    return -1;
  endfunction

  task automatic step(string tag, bit req, bit mon, int unsigned vpn,
                      bit ds, bit ls, bit lv, int unsigned lvpn, int unsigned lppn);
    int  k;
    bit  go, e_hit, e_miss;
    int unsigned e_ppn;
    @(negedge clk);
    lkp_req_i = req; lkp_mon_i = mon; lkp_vpn_i = PN_W'(vpn);
    dump_start_i = ds; load_start_i = ls;
    ld_vld_i = lv; ld_vpn_i = PN_W'(lvpn); ld_ppn_i = PN_W'(lppn);
    #1;
    go = req && (m_mode == 0);
    k = find(vpn);
    e_hit = go && (mon || k >= 0);
    e_miss = go && !mon && k < 0;
    e_ppn = !e_hit ? 0 : (mon ? vpn : m_ppn[k]);
    chk(tag, "busy", busy_o, m_mode != 0);
    chk(tag, "hit", lkp_hit_o, e_hit);
    chk(tag, "miss", lkp_miss_o, e_miss);
    chk(tag, "ppn", lkp_ppn_o, e_ppn);
    chk(tag, "dump_valid", dump_valid_o, m_mode == 1);
    if (m_mode == 1) begin
      chk(tag, "dump_idx", dump_idx_o, m_cnt);
      chk(tag, "dump_vld", dump_vld_o, m_vld[m_cnt]);
      chk(tag, "dump_vpn", dump_vpn_o, m_vpn[m_cnt]);
      chk(tag, "dump_ppn", dump_ppn_o, m_ppn[m_cnt]);
    end
    @(posedge clk);
    if (go && !mon && k >= 0) begin
      bit v0 = m_vld[k];
      int unsigned a = m_vpn[k], b = m_ppn[k];
      for (int j = k; j > 0; j--) begin
        m_vld[j] = m_vld[j-1]; m_vpn[j] = m_vpn[j-1]; m_ppn[j] = m_ppn[j-1];
      end
      m_vld[0] = v0; m_vpn[0] = a; m_ppn[0] = b;
    end
    if (m_mode == 2) begin
      m_vld[m_cnt] = lv; m_vpn[m_cnt] = lvpn; m_ppn[m_cnt] = lppn;
    end
    if (m_mode == 0) begin
      m_cnt = 0;
      if (ds) m_mode = 1; else if (ls) m_mode = 2;
    end else if (m_cnt == N - 1) begin
      m_mode = 0; m_cnt = 0;
    end else m_cnt++;
  endtask

  task automatic look(string tag, int unsigned vpn, bit mon = 1'b0);
    step(tag, 1'b1, mon, vpn, 1'b0, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic dump_all(string tag);
    step(tag, 1'b0, 1'b0, 0, 1'b1, 1'b0, 1'b0, 0, 0);
    for (int i = 0; i < N; i++)
      step(tag, 1'b1, 1'b0, 'h100, (i == 3), (i == 5), 1'b0, 0, 0);  // R8 during dump
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_bad++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; end
    m_mode = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1: reset state, empty array misses, dump shows zeros
    step("R1", 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 0, 0);
    look("R1", 'h100);
    look("R1", 0);
    dump_all("R1");

    // R7: block load; R8 lookups and starts ignored while loading
    step("R7", 1'b0, 1'b0, 0, 1'b0, 1'b1, 1'b0, 0, 0);
    for (int i = 0; i < N; i++) begin
      bit v = (i != 5);
      int unsigned vp = (i == 5) ? 'h777 : (i == 9) ? 'h103 : 'h100 + i;
      int unsigned pp = (i == 9) ? 'h999 : 'h800 + i;
      step("R7", 1'b1, 1'b0, 'h101, (i == 2), (i == 4), v, vp, pp);
    end
    // R8: both starts together while idle -> dump wins
    step("R8", 1'b0, 1'b0, 0, 1'b1, 1'b1, 1'b0, 0, 0);
    for (int i = 0; i < N; i++) step("R8", 1'b1, 1'b0, 'h102, 1'b0, 1'b0, 1'b0, 0, 0);

    // R2/R3 hits at several depths
    look("R3", 'h10A);
    look("R3", 'h10F);
    look("R2", 'h10A);
    look("R2", 'h100);
    // R10 duplicate 'h103: lowest position wins
    look("R10", 'h103);
    look("R10", 'h103);
    // R9 invalid entry never matches; R4 plain miss
    look("R9", 'h777);
    look("R4", 'h555);
    look("R4", 'h7FFFF);
    // R5 monitor identity, no reorder
    look("R5", 'h12345, 1'b1);
    look("R5", 'h10E, 1'b1);
    // R11 idle
    step("R11", 1'b0, 1'b0, 'h10E, 1'b0, 1'b0, 1'b0, 0, 0);
    dump_all("R6");

    // R3 long shuffle then dump of the order
    for (int i = 0; i < 2 * N; i++) look("R3", 'h100 + ((i * 7) % N));
    dump_all("R6");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule